// File: doc/BRIEF.md
# Fetch-Execute Pipeline Sequencer

This block steps a small core with separate program and data memories through its instructions. It divides the oscillator clock into four phases, and each group of four oscillator periods forms one instruction cycle. In every instruction cycle it fetches the next program word while the word fetched in the previous cycle is in execute. The program memory read address is presented for a whole cycle, with a one-clock strobe in the first phase. The word that memory returns in the last phase becomes the execute word for the next cycle.

Control-flow changes come back from execute as requests. A taken branch, jump, call or return loads a new fetch address. A skip discards the word that follows, and a skip over a two-word instruction discards two words. In both cases the prefetched words are replaced by no-operation slots, so the requesting instruction costs two or three instruction cycles. An untaken branch keeps the prefetched word and costs one cycle. For each instruction that finishes, the block reports how many instruction cycles it was charged.

Top module: `fetch_exec_seq`

## Requirements
- R1: A phase counter cycles through four phases, one per oscillator clock. `fetch_stb` is high in the first phase only, so it is high for one clock out of every four.
- R2: While `rst_n` is low, and for the first instruction cycle after it, `fetch_addr` is 0, `exec_valid` is 0, `exec_word` is the no-operation word (0) and `cyc_count` is 0.
- R3: `fetch_addr` changes only at the clock edge that ends the fourth phase. With no redirect taken it then grows by 2, wrapping modulo 2^ADDR_W.
- R4: The word on `imem_rdata` in the fourth phase becomes `exec_word` for the whole next instruction cycle, with `exec_valid` high, unless that slot is discarded.
- R5: A `br_take` sampled in the fourth phase of a valid slot loads `br_target` with bit 0 cleared into `fetch_addr` for the next cycle. The next slot is discarded, and `cyc_count` becomes 2.
- R6: A valid slot with neither request keeps the prefetched word (the next slot is valid), and `cyc_count` becomes 1.
- R7: A `skip_req` with `skip_two_word` low, sampled in the fourth phase of a valid slot, discards the next slot. The fetch address keeps advancing by 2, and `cyc_count` becomes 2.
- R8: A `skip_req` with `skip_two_word` high discards the next two slots, and `cyc_count` becomes 3.
- R9: Requests sampled while `exec_valid` is low have no effect: the address keeps advancing by 2, and the next slot is valid unless an earlier two-word skip still discards it. `cyc_count` is unchanged.
- R10: When `br_take` and `skip_req` are both high, the branch wins: only one slot is discarded, the target is loaded, and `cyc_count` becomes 2.
- R11: Requests are sampled only in the fourth phase. A request held only in the first three phases changes nothing.
- R12: A discarded slot shows `exec_word` equal to the no-operation word (0), with `exec_valid` low for the whole cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| imem_rdata | input | 16 | Program word read at `fetch_addr` |
| br_take | input | 1 | Control-flow change from the executing instruction |
| br_target | input | 21 | New fetch address for `br_take` |
| skip_req | input | 1 | Executing instruction skips its successor |
| skip_two_word | input | 1 | The skipped successor occupies two words |
| fetch_addr | output | 21 | Program memory byte address |
| fetch_stb | output | 1 | High in the first phase of each instruction cycle |
| exec_word | output | 16 | Instruction word in execute |
| exec_valid | output | 1 | Execute slot carries a real instruction |
| cyc_count | output | 2 | Instruction cycles charged to the last finished instruction |

## Verification
Every result of this block moves on the single edge that closes the fourth phase. At that edge the next fetch address, the execute word and its valid flag, and the cost of the finishing instruction all change together, and they then hold for four clocks. A request placed in the fourth phase is therefore visible one clock later. The two discarded slots of a two-word skip span the next eight clocks. The bench steps a behavioural model at each rising edge and compares every output on each falling edge, so that each result is checked in the clock where it is due and in every clock it must hold.

// File: rtl/fxs_pkg.sv
package fxs_pkg;

   typedef enum logic [1:0] {
      PH_Q1 = 2'd0,
      PH_Q2 = 2'd1,
      PH_Q3 = 2'd2,
      PH_Q4 = 2'd3
   } phase_t;

endpackage

// File: rtl/fxs_phase_gen.sv
module fxs_phase_gen
   import fxs_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   output phase_t phase,
   output logic   first_ph,
   output logic   last_ph
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase <= PH_Q1;
      else        phase <= phase_t'(phase + 2'd1);
   end

   assign first_ph = (phase == PH_Q1);
   assign last_ph  = (phase == PH_Q4);

   assert_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
      last_ph |=> first_ph);
   assert_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !last_ph |=> (2'(phase) == 2'($past(phase) + 2'd1)));

endmodule

// File: rtl/fxs_fetch_unit.sv
module fxs_fetch_unit #(
   parameter int ADDR_W  = 21,
   parameter int PC_STEP = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv,
   input  logic              redirect,
   input  logic [ADDR_W-1:0] target,
   output logic [ADDR_W-1:0] fetch_addr
);

   localparam int ALIGN_B = (PC_STEP > 1) ? $clog2(PC_STEP) : 0;

   logic [ADDR_W-1:0] aligned;

   generate
      if (ALIGN_B > 0) begin : g_align
         assign aligned = {target[ADDR_W-1:ALIGN_B], {ALIGN_B{1'b0}}};
      end else begin : g_noalign
         assign aligned = target;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        fetch_addr <= '0;
      else if (adv) begin
         if (redirect)   fetch_addr <= aligned;
         else            fetch_addr <= fetch_addr + ADDR_W'(PC_STEP);
      end
   end

   assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(fetch_addr));
   assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !redirect) |=> fetch_addr == ADDR_W'($past(fetch_addr) + ADDR_W'(PC_STEP)));
   assert_jump_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && redirect) |=> fetch_addr == {$past(target[ADDR_W-1:1]), 1'b0} || ALIGN_B != 1);

endmodule

// File: rtl/fxs_exec_stage.sv
module fxs_exec_stage #(
   parameter int              INSN_W   = 16,
   parameter logic [INSN_W-1:0] NOP_WORD = '0,
   parameter int              COST_W   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv,
   input  logic [INSN_W-1:0] fetched,
   input  logic              br_take,
   input  logic              skip_req,
   input  logic              skip_two_word,
   output logic              redirect,
   output logic [INSN_W-1:0] exec_word,
   output logic              exec_valid,
   output logic [COST_W-1:0] cyc_count
);

   logic [1:0]        squash_left;
   logic              take_skip;
   logic [COST_W-1:0] cost_now;

   assign redirect  = exec_valid && br_take;
   assign take_skip = exec_valid && skip_req && !br_take;

   always_comb begin
      if (redirect)       cost_now = COST_W'(2);
      else if (take_skip) cost_now = skip_two_word ? COST_W'(3) : COST_W'(2);
      else                cost_now = COST_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         exec_valid  <= 1'b0;
         exec_word   <= NOP_WORD;
         squash_left <= 2'd0;
         cyc_count   <= '0;
      end else if (adv) begin
         if (exec_valid) cyc_count <= cost_now;
         if (squash_left != 2'd0) begin
            exec_valid  <= 1'b0;
            exec_word   <= NOP_WORD;
            squash_left <= squash_left - 2'd1;
         end else if (redirect || take_skip) begin
            exec_valid  <= 1'b0;
            exec_word   <= NOP_WORD;
            squash_left <= (take_skip && skip_two_word) ? 2'd1 : 2'd0;
         end else begin
            exec_valid  <= 1'b1;
            exec_word   <= fetched;
         end
      end
   end

   assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(exec_valid) && $stable(exec_word) && $stable(cyc_count));
   assert_nop_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !exec_valid |-> exec_word == NOP_WORD);
   assert_branch_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && exec_valid && br_take) |=> !exec_valid && cyc_count == COST_W'(2));
   assert_short_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && exec_valid && skip_req && !skip_two_word && !br_take)
      |=> !exec_valid && cyc_count == COST_W'(2));
   assert_long_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && exec_valid && skip_req && skip_two_word && !br_take)
      |=> !exec_valid && cyc_count == COST_W'(3));
   assert_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !exec_valid) |=> $stable(cyc_count));

endmodule

// File: rtl/fetch_exec_seq.sv
module fetch_exec_seq
   import fxs_pkg::*;
#(
   parameter int                ADDR_W   = 21,
   parameter int                INSN_W   = 16,
   parameter int                PC_STEP  = 2,
   parameter logic [INSN_W-1:0] NOP_WORD = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [INSN_W-1:0] imem_rdata,
   input  logic              br_take,
   input  logic [ADDR_W-1:0] br_target,
   input  logic              skip_req,
   input  logic              skip_two_word,
   output logic [ADDR_W-1:0] fetch_addr,
   output logic              fetch_stb,
   output logic [INSN_W-1:0] exec_word,
   output logic              exec_valid,
   output logic [1:0]        cyc_count
);

   localparam int COST_W = 2;

   generate
      if (ADDR_W < 2 || ADDR_W > 32) begin : g_bad_aw
         $error("fetch_exec_seq: ADDR_W out of range");
      end
      if (INSN_W < 1) begin : g_bad_iw
         $error("fetch_exec_seq: INSN_W must be positive");
      end
      if (PC_STEP < 1 || (PC_STEP & (PC_STEP - 1)) != 0) begin : g_bad_step
         $error("fetch_exec_seq: PC_STEP must be a power of two");
      end
   endgenerate

   phase_t phase;
   logic   last_ph;
   logic   redirect;

   fxs_phase_gen u_phase (
      .clk      (clk),
      .rst_n    (rst_n),
      .phase    (phase),
      .first_ph (fetch_stb),
      .last_ph  (last_ph)
   );

   fxs_fetch_unit #(
      .ADDR_W  (ADDR_W),
      .PC_STEP (PC_STEP)
   ) u_fetch (
      .clk        (clk),
      .rst_n      (rst_n),
      .adv        (last_ph),
      .redirect   (redirect),
      .target     (br_target),
      .fetch_addr (fetch_addr)
   );

   fxs_exec_stage #(
      .INSN_W   (INSN_W),
      .NOP_WORD (NOP_WORD),
      .COST_W   (COST_W)
   ) u_exec (
      .clk           (clk),
      .rst_n         (rst_n),
      .adv           (last_ph),
      .fetched       (imem_rdata),
      .br_take       (br_take),
      .skip_req      (skip_req),
      .skip_two_word (skip_two_word),
      .redirect      (redirect),
      .exec_word     (exec_word),
      .exec_valid    (exec_valid),
      .cyc_count     (cyc_count)
   );

   assert_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_stb |=> !fetch_stb);
   assert_offphase_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != PH_Q4) |=> $stable(fetch_addr) && $stable(exec_valid));

endmodule

// File: tb/fetch_exec_seq_tb.sv
`timescale 1ns/1ps
module fetch_exec_seq_tb;

   localparam int AW = 21;
   localparam int IW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [IW-1:0] imem_rdata;
   logic          br_take = 1'b0;
   logic [AW-1:0] br_target = '0;
   logic          skip_req = 1'b0;
   logic          skip_two_word = 1'b0;
   logic [AW-1:0] fetch_addr;
   logic          fetch_stb;
   logic [IW-1:0] exec_word;
   logic          exec_valid;
   logic [1:0]    cyc_count;

   always #2.5 clk = ~clk;

   function automatic logic [IW-1:0] word_of(logic [AW-1:0] a);
      return IW'(a * 21'h0235) ^ 16'hC35A | 16'h8000;
   endfunction

   assign imem_rdata = word_of(fetch_addr);

   fetch_exec_seq u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .imem_rdata    (imem_rdata),
      .br_take       (br_take),
      .br_target     (br_target),
      .skip_req      (skip_req),
      .skip_two_word (skip_two_word),
      .fetch_addr    (fetch_addr),
      .fetch_stb     (fetch_stb),
      .exec_word     (exec_word),
      .exec_valid    (exec_valid),
      .cyc_count     (cyc_count)
   );

   // behavioural reference
   int            m_ph;
   logic [AW-1:0] m_pc;
   logic          m_valid;
   logic [IW-1:0] m_word;
   int            m_squash;
   int            m_cost;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ph = 0; m_pc = '0; m_valid = 1'b0; m_word = '0; m_squash = 0; m_cost = 0;
      end else begin
         if (m_ph == 3) begin
            bit tr, ts;
            tr = m_valid && br_take;
            ts = m_valid && skip_req && !br_take;
            if (m_valid) m_cost = tr ? 2 : (ts ? (skip_two_word ? 3 : 2) : 1);
            if (m_squash > 0) begin
               m_valid = 1'b0; m_word = '0; m_squash--;
            end else if (tr || ts) begin
               m_valid = 1'b0; m_word = '0; m_squash = (ts && skip_two_word) ? 1 : 0;
            end else begin
               m_valid = 1'b1; m_word = word_of(m_pc);
            end
            m_pc = tr ? {br_target[AW-1:1], 1'b0} : AW'(m_pc + 2);
         end
         m_ph = (m_ph + 1) % 4;
      end
   end

   int    n_cmp = 0;
   int    n_bad = 0;
   bit    done = 1'b0;
   string cur_req = "R2";

   task automatic check(string nm, logic [31:0] got, logic [31:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s got %h expected %h at %0t", cur_req, nm, got, exp, $time);
      end
   endtask

   task automatic compare();
      check("fetch_addr", 32'(fetch_addr), 32'(m_pc));
      check("fetch_stb",  32'(fetch_stb),  32'(m_ph == 0));
      check("exec_valid", 32'(exec_valid), 32'(m_valid));
      check("exec_word",  32'(exec_word),  32'(m_word));
      check("cyc_count",  32'(cyc_count),  32'(m_cost));
   endtask

   task automatic tick();
      @(negedge clk);
      compare();
   endtask

   task automatic run(int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   // request held during the fourth phase only
   task automatic do_req(bit r, bit s, bit two, logic [AW-1:0] tgt);
      while (m_ph != 3) tick();
      br_take = r; skip_req = s; skip_two_word = two; br_target = tgt;
      tick();
      br_take = 1'b0; skip_req = 1'b0; skip_two_word = 1'b0;
   endtask

   initial begin
      cur_req = "R2";
      run(6);
      rst_n = 1'b1;
      run(4);                                  // first cycle has no valid slot (R2)
      cur_req = "R1"; run(8);
      cur_req = "R3"; run(16);
      cur_req = "R4"; run(8);
      cur_req = "R6"; run(8);
      cur_req = "R5"; do_req(1, 0, 0, 21'h01235); run(12);
      cur_req = "R5"; do_req(1, 0, 0, 21'h1FFFFE); run(20);   // wrap after target (R3)
      cur_req = "R7"; do_req(0, 1, 0, '0); run(12);
      cur_req = "R8"; do_req(0, 1, 1, '0); run(16);
      cur_req = "R9"; do_req(1, 0, 0, 21'h00400);
      do_req(1, 0, 0, 21'h00800);              // slot invalid: ignored
      run(12);
      cur_req = "R9"; do_req(0, 1, 1, '0);
      do_req(1, 1, 0, 21'h00900);              // during first discarded slot
      do_req(0, 1, 0, '0);                     // during second discarded slot
      run(12);
      cur_req = "R10"; do_req(1, 1, 1, 21'h00AA1); run(12);
      cur_req = "R11";
      while (m_ph != 1) tick();
      br_take = 1'b1; br_target = 21'h00C00; skip_req = 1'b1;
      tick(); tick();
      br_take = 1'b0; skip_req = 1'b0;
      run(12);
      cur_req = "R12"; do_req(0, 1, 1, '0); run(8);
      cur_req = "R6"; run(8);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(5.0 * 200000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired got hang expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule